// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

A single-clock static memory of 36-bit words, each made of four 9-bit lanes. Chip select, write enable, lane write enables and address are sampled on every rising edge. A read presents its address at one edge. The word is loaded into an output register at the next edge and is driven during the cycle after it. A write presents its full address and lane mask at one edge and its data at the following edge.

Write data is not placed in the array straight away. It is parked in a one-entry posted buffer that carries the address, a per-lane valid mask and the data. The buffer is written into the array only when the next write address is accepted. A read whose address matches the buffer takes the valid lanes from the buffer and the other lanes from the array, so a read always returns the latest data.

The bus is split into an input word and an output word with a drive qualifier, in place of a bidirectional pin. An asynchronous output enable and an asynchronous sleep input both release the output. While sleep is high, every clock edge is ignored and all state is held. The depth is set by the address-width parameter.

Top module: `lwsram_core`

## Requirements
- R1: A read cycle (sel_n=0, wen_n=1) accepted at edge n makes `rdata_drive`=1 and `rdata` equal to the word at that address during the cycle after edge n+1. This holds when oe_n=0 and sleep=0, and when edge n+1 is an awake edge.
- R2: A write cycle (sel_n=0, wen_n=0, at least one lane enabled) takes its whole address at edge n. It takes its data from `wdata` at the next awake edge.
- R3: `lane_wen_n` bit i is active low and selects data bits [9i+8:9i], with lane a at bit 0. Only enabled lanes change, and any combination may be written.
- R4: Posted write data stays in a one-entry buffer until the next write address arrives. A read that hits the buffered address returns the buffered lanes merged with the array lanes.
- R5: A read issued in the cycle right after a write to the same address returns the newly written lanes.
- R6: Two writes to one address with different lane masks leave every lane written by either, the later one winning on overlap.
- R7: A deselect cycle (sel_n=1) gives `rdata_drive`=0 after the following edge. So does a write cycle or a dummy cycle.
- R8: A dummy cycle (sel_n=0, wen_n=0, all lane_wen_n high) writes nothing and leaves both the buffer and the array unchanged.
- R9: oe_n=1 forces `rdata_drive`=0 and `rdata`=0 at once, without waiting for a clock edge.
- R10: sleep=1 forces `rdata_drive`=0 at once. Every edge sampled with sleep=1 is ignored, and all state is held until sleep falls.
- R11: rst_n=0 at a rising edge empties the write buffer and idles the output register, so `rdata_drive`=0.
- R12: Whenever `rdata_drive`=0, `rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| wen_n | input | 1 | Write enable, active low |
| lane_wen_n | input | LANES | Per-lane write enables, active low, bit 0 = lane a |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, given one cycle after its address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep; ignores edges and releases output |
| rdata | output | LANES*LANE_W | Read data, zero while not driven |
| rdata_drive | output | 1 | High while the core drives `rdata` |

## Verification
On every edge, the assertions check the following:
- a read arms the output stage;
- a deselect disarms it;
- a write loads the buffer's address and lane mask;
- a dummy cycle leaves the buffer alone;
- a sleeping edge freezes the output and buffer state.

The data itself is checked only by the bench's scenarios, by comparison with a latest-data model. These scenarios cover:
- bypass from the buffer on reads right after a write;
- lane merging across back-to-back writes to one address;
- values surviving commit into the array;
- the asynchronous effect of output enable and sleep within a cycle.

// File: rtl/lwsram_pkg.sv
// Shared types for the late-write SRAM core.
package lwsram_pkg;
    // Cycle kind decoded from the sampled controls; OP_NONE means the edge is ignored.
    typedef enum logic [2:0] {
        OP_NONE,
        OP_DESEL,
        OP_READ,
        OP_WRITE,
        OP_DUMMY
    } op_t;
endpackage

// File: rtl/lwsram_ctrl.sv
// Cycle decoder: turns chip select, write enable, lane enables and sleep into
// one cycle kind. Assumes the inputs are stable around the rising edge.
module lwsram_ctrl #(
    parameter int LANES = 4
) (
    input  logic                 sleep,
    input  logic                 sel_n,
    input  logic                 wen_n,
    input  logic [LANES-1:0]     lane_wen_n,
    output lwsram_pkg::op_t      op
);
    import lwsram_pkg::*;

    // Priority: sleep, then deselect, then read, then write or dummy.
    always_comb begin
        if (sleep)                op = OP_NONE;
        else if (sel_n)           op = OP_DESEL;
        else if (wen_n)           op = OP_READ;
        else if (&lane_wen_n)     op = OP_DUMMY;
        else                      op = OP_WRITE;
    end
endmodule

// File: rtl/lwsram_array.sv
// Storage array: synchronous lane-masked write, combinational read.
// Not reset; its contents are defined only once written.
module lwsram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [LANES-1:0]          wmask,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [LANES*LANE_W-1:0]   rdata
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = LANES * LANE_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Commit the enabled lanes of one word.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < LANES; i++) begin
                if (wmask[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
            end
        end
    end

    // Asynchronous read port used by the output stage.
    assign rdata = mem[raddr];
endmodule

// File: rtl/lwsram_wbuf.sv
// One-entry posted write buffer. A write address loads the address and lane
// mask, and the data is captured at the next awake edge. The old entry is
// committed to the array in the same edge as the next write address. Assumes
// only one cycle kind per edge.
module lwsram_wbuf #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  lwsram_pkg::op_t           op,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES-1:0]          lane_wen_n,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [ADDR_W-1:0]         buf_addr,
    output logic [LANES-1:0]          buf_mask,
    output logic [LANES*LANE_W-1:0]   buf_data,
    output logic                      commit_en,
    output logic [LANES*LANE_W-1:0]   commit_data
);
    import lwsram_pkg::*;

    logic data_pend;

    // Data still on the bus belongs to the entry when the capture is due now.
    assign commit_data = data_pend ? wdata : buf_data;
    assign commit_en   = (op == OP_WRITE) && (|buf_mask);

    // Buffer entry update: load on write, capture data one awake edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_addr  <= '0;
            buf_mask  <= '0;
            buf_data  <= '0;
            data_pend <= 1'b0;
        end else begin
            case (op)
                OP_WRITE: begin
                    buf_addr  <= addr;
                    buf_mask  <= ~lane_wen_n;
                    data_pend <= 1'b1;
                end
                OP_NONE: ;
                default: begin
                    if (data_pend) buf_data <= wdata;
                    data_pend <= 1'b0;
                end
            endcase
        end
    end

    // R4: a write address replaces the entry's address and lane mask.
    p_write_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> (buf_addr == $past(addr)) && (buf_mask == ~$past(lane_wen_n)));

    // R8: a dummy cycle leaves the entry's address and mask as they were.
    p_dummy_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DUMMY) |=> $stable(buf_addr) && $stable(buf_mask));
endmodule

// File: rtl/lwsram_rdpath.sv
// Read pipeline: registers the read address at one edge and merges the array
// word with the buffer lanes on an address hit. The result goes into the
// output register at the next awake edge. Assumes the array read is
// combinational.
module lwsram_rdpath #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  lwsram_pkg::op_t           op,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   arr_rdata,
    input  logic [ADDR_W-1:0]         buf_addr,
    input  logic [LANES-1:0]          buf_mask,
    input  logic [LANES*LANE_W-1:0]   buf_data,
    output logic [ADDR_W-1:0]         rd_addr_q,
    output logic                      rd_pend,
    output logic                      out_vld,
    output logic [LANES*LANE_W-1:0]   out_data
);
    import lwsram_pkg::*;

    logic                    hit;
    logic [LANES*LANE_W-1:0] merged;

    assign hit = (rd_addr_q == buf_addr);

    // Per-lane bypass: a valid buffered lane overrides the array lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] = (hit && buf_mask[g]) ?
            buf_data[g*LANE_W +: LANE_W] : arr_rdata[g*LANE_W +: LANE_W];
    end

    // Two-stage read pipeline; ignored edges hold every stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr_q <= '0;
            rd_pend   <= 1'b0;
            out_vld   <= 1'b0;
            out_data  <= '0;
        end else if (op != OP_NONE) begin
            out_vld <= rd_pend;
            if (rd_pend) out_data <= merged;
            rd_pend <= (op == OP_READ);
            if (op == OP_READ) rd_addr_q <= addr;
        end
    end
endmodule

// File: rtl/lwsram_core.sv
// Late-write synchronous SRAM core. A read is driven in the cycle after the
// edge that follows its address. Write data follows its address by one
// cycle and waits in a posted buffer until the next write address.
// Assumes single-clock use.
module lwsram_core #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_n,
    input  logic                      wen_n,
    input  logic [LANES-1:0]          lane_wen_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic                      oe_n,
    input  logic                      sleep,
    output logic [LANES*LANE_W-1:0]   rdata,
    output logic                      rdata_drive
);
    import lwsram_pkg::*;

    localparam int WORD_W = LANES * LANE_W;

    op_t               op;
    logic [ADDR_W-1:0] buf_addr;
    logic [LANES-1:0]  buf_mask;
    logic [WORD_W-1:0] buf_data;
    logic              commit_en;
    logic [WORD_W-1:0] commit_data;
    logic [WORD_W-1:0] arr_rdata;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              rd_pend;
    logic              out_vld;
    logic [WORD_W-1:0] out_data;

    lwsram_ctrl #(.LANES(LANES)) ctrl_i (
        .sleep(sleep), .sel_n(sel_n), .wen_n(wen_n),
        .lane_wen_n(lane_wen_n), .op(op)
    );

    lwsram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) wbuf_i (
        .clk(clk), .rst_n(rst_n), .op(op), .addr(addr), .lane_wen_n(lane_wen_n),
        .wdata(wdata), .buf_addr(buf_addr), .buf_mask(buf_mask), .buf_data(buf_data),
        .commit_en(commit_en), .commit_data(commit_data)
    );

    lwsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk(clk), .we(commit_en), .waddr(buf_addr), .wmask(buf_mask),
        .wdata(commit_data), .raddr(rd_addr_q), .rdata(arr_rdata)
    );

    lwsram_rdpath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) rdpath_i (
        .clk(clk), .rst_n(rst_n), .op(op), .addr(addr), .arr_rdata(arr_rdata),
        .buf_addr(buf_addr), .buf_mask(buf_mask), .buf_data(buf_data),
        .rd_addr_q(rd_addr_q), .rd_pend(rd_pend), .out_vld(out_vld), .out_data(out_data)
    );

    // Asynchronous release by output enable and sleep; idle bus reads as zero.
    assign rdata_drive = out_vld & ~oe_n & ~sleep;
    assign rdata       = rdata_drive ? out_data : '0;

    // R1: an accepted read arms the output stage for the next edge.
    p_read_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ) |=> rd_pend);

    // R7: a deselect leaves nothing to drive after the following edge.
    p_desel_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DESEL) |=> !rd_pend);

    // R10: an edge seen while asleep changes no pipeline or buffer state.
    p_sleep_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(out_vld) && $stable(rd_pend) && $stable(buf_mask) && $stable(out_data));
endmodule

// File: tb/lwsram_core_tb_top.sv
// Bench: a behavioural latest-data model, compared with the ports on every
// falling edge.
module lwsram_core_tb_top;
    localparam int AW = 8;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int WW = LN * LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic wen_n = 1'b1;
    logic oe_n = 1'b0;
    logic sleep = 1'b0;
    logic [LN-1:0] lane_n = '1;
    logic [AW-1:0] addr = '0;
    logic [WW-1:0] wdata = '0;
    logic [WW-1:0] next_wd = '0;
    logic [WW-1:0] rdata;
    logic          drv;

    always #10 clk = ~clk;

    lwsram_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wen_n(wen_n), .lane_wen_n(lane_n),
        .addr(addr), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
        .rdata(rdata), .rdata_drive(drv)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R11";
    bit    done = 0;

    // Reference model state: memory holding the latest data, a pending write, a pending read, the output.
    logic [WW-1:0] mem_m [int];
    bit            pw = 0;
    int            pa = 0;
    logic [LN-1:0] pl = '0;
    bit            rq = 0;
    int            ra = 0;
    bit            ev = 0;
    logic [WW-1:0] ed = '0;

    // Model update on every rising edge.
    always @(posedge clk) begin
        logic [WW-1:0] w;
        if (!rst_n) begin
            pw = 0; rq = 0; ev = 0;
        end else if (!sleep) begin
            if (pw) begin
                w = mem_m.exists(pa) ? mem_m[pa] : '0;
                for (int i = 0; i < LN; i++) if (pl[i]) w[i*LW +: LW] = wdata[i*LW +: LW];
                mem_m[pa] = w;
                pw = 0;
            end
            ev = rq;
            if (rq) ed = mem_m.exists(ra) ? mem_m[ra] : '0;
            rq = 0;
            if (!sel_n) begin
                if (wen_n) begin rq = 1; ra = int'(addr); end
                else if (lane_n != '1) begin pw = 1; pa = int'(addr); pl = ~lane_n; end
            end
        end
    end

    // Per-cycle comparison away from the active edge (covers R9/R10/R12 levels too).
    always @(negedge clk) begin
        logic          exp_d;
        logic [WW-1:0] exp_r;
        if (!done) begin
            exp_d = ev && !oe_n && !sleep;
            exp_r = exp_d ? ed : '0;
            checks++;
            if (drv !== exp_d || rdata !== exp_r) begin
                errors++;
                $display("FAIL %s: drive=%0b rdata=%h expected drive=%0b rdata=%h",
                         tag, drv, rdata, exp_d, exp_r);
            end
        end
    end

    // One bus cycle; wdata carries the data of the previous cycle's write.
    task automatic cyc(input bit s, input bit w, input logic [LN-1:0] ln_n,
                       input int a, input logic [WW-1:0] d);
        sel_n  = s; wen_n = w; lane_n = ln_n; addr = AW'(a);
        wdata  = next_wd;
        next_wd = (!s && !w) ? d : {$urandom, $urandom};
        @(posedge clk);
        #1;
    endtask

    task automatic do_read(input int a);   cyc(0, 1, '1, a, '0);  endtask
    task automatic do_desel();             cyc(1, 1, '1, 0, '0);  endtask
    task automatic do_dummy(input int a);  cyc(0, 0, '1, a, '0);  endtask
    task automatic do_write(input int a, input logic [LN-1:0] lanes, input logic [WW-1:0] d);
        cyc(0, 0, ~lanes, a, d);
    endtask

    function automatic logic [WW-1:0] pat(input int a);
        return {4'h5, 32'(a * 32'h01010101 + 32'h1234)};
    endfunction

    initial begin
        // R11: reset state with the bus released.
        tag = "R11";
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        do_desel();

        // R2: fill addresses 0..15 with full-word writes (data one cycle late).
        tag = "R2";
        for (int a = 0; a < 16; a++) do_write(a, 4'hF, pat(a));
        do_desel();

        // R1: read every word back; latency checked per cycle.
        tag = "R1";
        for (int a = 0; a < 16; a++) do_read(a);
        do_desel(); do_desel();

        // R3: single- and mixed-lane writes; lane a is bit 0.
        tag = "R3";
        do_write(2, 4'b0001, {WW{1'b1}});
        do_write(3, 4'b1010, 36'h0_0000_0000);
        do_write(4, 4'b0110, 36'h1_2345_6789);
        do_write(9, 4'hF, 36'hA_BCDE_F012);
        do_read(2); do_read(3); do_read(4);

        // R4: read the buffered address several times before any commit.
        tag = "R4";
        do_write(7, 4'b1100, 36'hF_0F0F_0F0F);
        do_read(7); do_read(8); do_read(7);
        do_desel(); do_read(7);

        // R5: read right after a write to the same address.
        tag = "R5";
        do_write(5, 4'hF, 36'h9_8765_4321);
        do_read(5);
        do_write(5, 4'b0010, 36'h0_0000_0000);
        do_read(5);

        // R6: back-to-back writes to one address with different lanes.
        tag = "R6";
        do_write(6, 4'b0011, 36'h1_1111_1111);
        do_write(6, 4'b1110, 36'h2_2222_2222);
        do_read(6);
        do_write(10, 4'hF, 36'h3_3333_3333);
        do_read(6); do_read(10);

        // R7: deselect between reads releases the bus.
        tag = "R7";
        do_read(1); do_desel(); do_read(2); do_desel(); do_desel();
        do_write(11, 4'hF, 36'h4_4444_4444); do_desel(); do_read(11);

        // R8: dummy cycles change neither buffer nor array.
        tag = "R8";
        do_write(12, 4'b0101, 36'h5_5555_5555);
        do_dummy(12); do_dummy(13);
        do_read(12); do_read(13);

        // R9: output enable released mid-cycle, with no clock edge.
        tag = "R9";
        do_read(4); do_read(5);
        #5 oe_n = 1'b1;
        @(posedge clk); #1;
        oe_n = 1'b0;
        do_read(6);
        #4 oe_n = 1'b1;
        #10 oe_n = 1'b0;
        do_desel();

        // R10: sleep ignores writes/reads and releases the bus at once.
        tag = "R10";
        do_read(9);
        #3 sleep = 1'b1;
        do_write(9, 4'hF, 36'h6_6666_6666);
        do_read(3); do_write(14, 4'hF, 36'h7_7777_7777);
        sleep = 1'b0;
        do_read(9); do_read(14); do_desel();

        // R12: random mix; idle bus must read zero.
        tag = "R12";
        for (int k = 0; k < 400; k++) begin
            int r = $urandom_range(0, 9);
            int a = $urandom_range(0, 15);
            oe_n  = ($urandom_range(0, 9) == 0);
            sleep = ($urandom_range(0, 19) == 0);
            if (r < 4)       do_read(a);
            else if (r < 7)  do_write(a, 4'($urandom_range(1, 15)), {$urandom, $urandom});
            else if (r < 8)  do_dummy(a);
            else             do_desel();
        end
        oe_n = 1'b0; sleep = 1'b0;
        do_desel(); do_desel();

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL %s: watchdog expired", tag);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule